// File: doc/BRIEF.md
# Multi-Mode Position Counter with Flags

This block is a parameterised up/down position counter meant to sit behind an encoder front end. The front end supplies one qualified count pulse per step together with a direction bit and an already-filtered active-low index level. Software-visible configuration arrives as two plain configuration words: a mode word, which picks the wrap policy and the role of the index input, and a flag word, which shapes the two flag pins. A limit word doubles as range bound, modulo divisor and compare target.

The counter follows one of four policies. Free-running wraps through the full range. Single-cycle halts after its first wrap. Range-limit freezes at the limit going up and at zero going down. Modulo-N folds back between zero and the limit. Every accepted step may raise carry, borrow or compare events, and a falling edge on the index raises an index event. These events feed a sticky status, a sign indicator and two active-low/high flag pins. Strobes let the surrounding logic clear or load the counter, snapshot it into a hold register, and clear the recorded status. The index can be programmed to do the clear, the load or the snapshot by itself.

Top module: `pos_counter`

## Requirements
- R1: After a clock with `rst_n` low: counter and snapshot are 0, all event outputs are 0, `sign_o`=0, `dir_up`=1, `flag_a_n`=1; with `flag_cfg`=0 then `flag_b`=1 and `cnt_en`=1.
- R2: Policy `mode_cfg[1:0]`=00 (free-running): an accepted up pulse adds 1 and a down pulse subtracts 1; stepping up from all ones to 0 raises `evt_carry`, and stepping down from 0 to all ones raises `evt_borrow`. Every event output is high for exactly the one cycle after the edge that caused it, which is the cycle in which the counter shows its new value.
- R3: Policy 01 (single-cycle) counts like free-running, but the wrapping step that raises carry or borrow also drops `cnt_en` and further pulses are ignored. A counter clear or load raises `cnt_en` again.
- R4: Policy 10 (range-limit): an up pulse with the counter equal to `limit_val`, and a down pulse with the counter at 0, leave the counter unchanged. Pulses in the opposite direction move it again.
- R5: Policy 11 (modulo-N): an up pulse at `limit_val` gives 0 and raises `evt_carry`, and a down pulse at 0 gives `limit_val` and raises `evt_borrow`. This yields a cycle of `limit_val`+1 states.
- R6: `evt_cmp` is raised by a step that changes the counter to a value equal to `limit_val`. Under policies 00 and 01 this holds in both directions; under 10 and 11 only when counting up.
- R7: `flag_cfg` bits 0,1,2,3 enable carry, borrow, compare and index respectively onto `flag_a_n`, and the enabled sources are OR-combined. With `flag_cfg[7]`=0 (latched), `flag_a_n` goes low in the cycle an enabled event shows and stays low until a `clr_stat` strobe. A strobe discards all recorded events, including one showing in the cycle of the strobe.
- R8: With `flag_cfg[7]`=1 (pulsed), `flag_a_n` is low only in the cycle that an enabled event output is high.
- R9: `flag_cfg[5:4]` selects `flag_b`: 00 gives high, 01 gives `sign_o`, 10 gives `dir_up` (direction of the last accepted pulse, 1 = up), and 11 gives high.
- R10: `flag_cfg[6]`=1 drops `cnt_en`, and count pulses then leave the counter unchanged.
- R11: `mode_cfg[3:2]` sets the index role on each falling edge of `idx_n`: 00 none, 01 load the counter from `limit_val`, 10 clear the counter, 11 copy the counter into `snap_val`. Every falling edge raises `evt_idx` for one cycle, and holding `idx_n` low raises no further events.
- R12: A clear and a load in the same cycle give 0. A clear or load wins over a count pulse in the same cycle. A snapshot (`snap_req` or index) captures the counter value from before that edge.
- R13: `sign_o` is set by every borrow event and cleared by every carry event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_pulse | input | 1 | Qualified count pulse, one step per cycle high |
| cnt_up | input | 1 | Count direction, 1 = up |
| idx_n | input | 1 | Qualified index level, active low |
| mode_cfg | input | 4 | [1:0] wrap policy, [3:2] index role |
| flag_cfg | input | 8 | [3:0] flag A sources, [5:4] flag B select, [6] count disable, [7] flag A pulsed |
| limit_val | input | WIDTH | Limit, divisor and compare target; load source |
| clr_cnt | input | 1 | Clear counter strobe |
| ld_cnt | input | 1 | Load counter from `limit_val` strobe |
| snap_req | input | 1 | Copy counter into snapshot strobe |
| clr_stat | input | 1 | Clear recorded events strobe |
| cnt_val | output | WIDTH | Counter value |
| snap_val | output | WIDTH | Snapshot register |
| evt_carry | output | 1 | Carry event, one cycle |
| evt_borrow | output | 1 | Borrow event, one cycle |
| evt_cmp | output | 1 | Compare event, one cycle |
| evt_idx | output | 1 | Index event, one cycle |
| sign_o | output | 1 | Sign indicator |
| dir_up | output | 1 | Direction of last accepted pulse |
| cnt_en | output | 1 | Live count enable |
| flag_a_n | output | 1 | Combined event flag, active low |
| flag_b | output | 1 | Sign or direction flag |

## Verification
The bench drives the counter across the all-ones/zero seam in each policy. A wrong wrap test would show as a missing or doubled carry or borrow, or in single-cycle mode as a counter that keeps running. It approaches the limit from both sides in range and modulo modes, where an erroneous design would fire compare on a downward landing or step past the freeze point. It holds the index low for several cycles and lines strobes up against count pulses in the same cycle. This exposes level-instead-of-edge index handling, a load beating a clear, or a snapshot taking the post-edge value. It also lets a status clear coincide with a fresh event, so the latched flag's clear-versus-set ordering is pinned down.

// File: rtl/pos_counter_pkg.sv
// Shared encodings for the position counter.
// Assumes: configuration fields are decoded exactly as enumerated here.
package pos_counter_pkg;

    typedef enum logic [1:0] {
        POL_FREE  = 2'b00,
        POL_ONCE  = 2'b01,
        POL_RANGE = 2'b10,
        POL_MODN  = 2'b11
    } policy_e;

    typedef enum logic [1:0] {
        IDX_OFF   = 2'b00,
        IDX_LOAD  = 2'b01,
        IDX_CLEAR = 2'b10,
        IDX_SNAP  = 2'b11
    } idx_role_e;

    typedef enum logic [1:0] {
        FB_HIGH = 2'b00,
        FB_SIGN = 2'b01,
        FB_DIR  = 2'b10,
        FB_RSVD = 2'b11
    } flagb_sel_e;

    // Bit order matches the flag A source enables: carry at bit 0.
    typedef struct packed {
        logic idx;
        logic cmp;
        logic borrow;
        logic carry;
    } evt_t;

endpackage

// File: rtl/pc_step.sv
// Next-value function for one accepted count step under each wrap policy.
// Purely combinational; assumes the caller gates it with a real step.
module pc_step
    import pos_counter_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] limit,
    input  logic             up,
    input  policy_e          policy,
    output logic [WIDTH-1:0] nxt,
    output logic             wrap_up,
    output logic             wrap_dn,
    output logic             hit
);

    localparam logic [WIDTH-1:0] ALL1 = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ZERO = {WIDTH{1'b0}};

    logic [WIDTH-1:0] inc;
    logic [WIDTH-1:0] dec;

    assign inc = cur + 1'b1;
    assign dec = cur - 1'b1;

    // Select next value and wrap indications by policy.
    always_comb begin
        nxt     = cur;
        wrap_up = 1'b0;
        wrap_dn = 1'b0;
        unique case (policy)
            POL_FREE, POL_ONCE: begin
                nxt     = up ? inc : dec;
                wrap_up = up && (cur == ALL1);
                wrap_dn = !up && (cur == ZERO);
            end
            POL_RANGE: begin
                if (up && (cur != limit)) nxt = inc;
                else if (!up && (cur != ZERO)) nxt = dec;
            end
            POL_MODN: begin
                if (up) begin
                    wrap_up = (cur == limit);
                    nxt     = wrap_up ? ZERO : inc;
                end else begin
                    wrap_dn = (cur == ZERO);
                    nxt     = wrap_dn ? limit : dec;
                end
            end
            default: nxt = cur;
        endcase
    end

    // Compare fires on a move onto the limit; bounded policies only upward.
    assign hit = (nxt != cur) && (nxt == limit) &&
                 (up || (policy == POL_FREE) || (policy == POL_ONCE));

endmodule

// File: rtl/pc_core.sv
// Counter register, single-cycle halt, sign, direction and event registers.
// Assumes do_clr/do_ld already merge strobes with the index role.
module pc_core
    import pos_counter_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse,
    input  logic             up,
    input  policy_e          policy,
    input  logic             count_off,
    input  logic [WIDTH-1:0] limit,
    input  logic             do_clr,
    input  logic             do_ld,
    input  logic             idx_evt,
    output logic [WIDTH-1:0] cnt_q,
    output evt_t             evt_q,
    output logic             sign_q,
    output logic             dir_q,
    output logic             cnt_en
);

    logic             halted_q;
    logic             take;
    logic [WIDTH-1:0] step_nxt;
    logic             step_cy;
    logic             step_bw;
    logic             step_hit;

    pc_step #(.WIDTH(WIDTH)) u_step (
        .cur     (cnt_q),
        .limit   (limit),
        .up      (up),
        .policy  (policy),
        .nxt     (step_nxt),
        .wrap_up (step_cy),
        .wrap_dn (step_bw),
        .hit     (step_hit)
    );

    assign cnt_en = !count_off && !halted_q;
    assign take   = pulse && cnt_en && !do_clr && !do_ld;

    // Counter value: clear beats load beats step.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (do_clr) cnt_q <= '0;
        else if (do_ld)  cnt_q <= limit;
        else if (take)   cnt_q <= step_nxt;
    end

    // Single-cycle halt: set on a wrap, released by clear or load.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          halted_q <= 1'b0;
        else if (do_clr || do_ld)                            halted_q <= 1'b0;
        else if (take && (policy == POL_ONCE) && (step_cy || step_bw)) halted_q <= 1'b1;
    end

    // Sign and last direction track accepted steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sign_q <= 1'b0;
            dir_q  <= 1'b1;
        end else if (take) begin
            dir_q <= up;
            if (step_bw)      sign_q <= 1'b1;
            else if (step_cy) sign_q <= 1'b0;
        end
    end

    // One-cycle event register.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= '{idx: idx_evt, cmp: take && step_hit,
                               borrow: take && step_bw, carry: take && step_cy};
    end

endmodule

// File: rtl/pc_flags.sv
// Sticky status and flag pin shaping.
// Assumes evt is a one-cycle registered event vector.
module pc_flags
    import pos_counter_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  evt_t       evt,
    input  logic       clr_stat,
    input  logic [3:0] src_en,
    input  logic       pulse_mode,
    input  flagb_sel_e b_sel,
    input  logic       sign,
    input  logic       dir,
    output logic       flag_a_n,
    output logic       flag_b
);

    logic [3:0] sticky_q;
    logic [3:0] seen;

    // Record shown events until a status clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        sticky_q <= '0;
        else if (clr_stat) sticky_q <= '0;
        else               sticky_q <= sticky_q | evt;
    end

    assign seen = pulse_mode ? evt : (sticky_q | evt);

    // Flag A: low while any enabled source is active.
    assign flag_a_n = ~|(seen & src_en);

    // Flag B source select.
    always_comb begin
        unique case (b_sel)
            FB_SIGN: flag_b = sign;
            FB_DIR:  flag_b = dir;
            default: flag_b = 1'b1;
        endcase
    end

endmodule

// File: rtl/pos_counter.sv
// Multi-mode position counter top: index edge, request merge, snapshot.
// Assumes cnt_pulse, cnt_up and idx_n are already synchronous and filtered.
module pos_counter
    import pos_counter_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_pulse,
    input  logic             cnt_up,
    input  logic             idx_n,
    input  logic [3:0]       mode_cfg,
    input  logic [7:0]       flag_cfg,
    input  logic [WIDTH-1:0] limit_val,
    input  logic             clr_cnt,
    input  logic             ld_cnt,
    input  logic             snap_req,
    input  logic             clr_stat,
    output logic [WIDTH-1:0] cnt_val,
    output logic [WIDTH-1:0] snap_val,
    output logic             evt_carry,
    output logic             evt_borrow,
    output logic             evt_cmp,
    output logic             evt_idx,
    output logic             sign_o,
    output logic             dir_up,
    output logic             cnt_en,
    output logic             flag_a_n,
    output logic             flag_b
);

    policy_e   policy;
    idx_role_e role;
    logic      idx_prev_q;
    logic      idx_fall;
    logic      do_clr;
    logic      do_ld;
    logic      do_snap;
    evt_t      evt;

    assign policy = policy_e'(mode_cfg[1:0]);
    assign role   = idx_role_e'(mode_cfg[3:2]);

    // Remember previous index level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_prev_q <= 1'b1;
        else        idx_prev_q <= idx_n;
    end

    assign idx_fall = idx_prev_q && !idx_n;
    assign do_clr   = clr_cnt  || (idx_fall && (role == IDX_CLEAR));
    assign do_ld    = ld_cnt   || (idx_fall && (role == IDX_LOAD));
    assign do_snap  = snap_req || (idx_fall && (role == IDX_SNAP));

    // Snapshot register takes the pre-edge counter.
    always_ff @(posedge clk) begin
        if (!rst_n)       snap_val <= '0;
        else if (do_snap) snap_val <= cnt_val;
    end

    pc_core #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse     (cnt_pulse),
        .up        (cnt_up),
        .policy    (policy),
        .count_off (flag_cfg[6]),
        .limit     (limit_val),
        .do_clr    (do_clr),
        .do_ld     (do_ld),
        .idx_evt   (idx_fall),
        .cnt_q     (cnt_val),
        .evt_q     (evt),
        .sign_q    (sign_o),
        .dir_q     (dir_up),
        .cnt_en    (cnt_en)
    );

    pc_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .clr_stat   (clr_stat),
        .src_en     (flag_cfg[3:0]),
        .pulse_mode (flag_cfg[7]),
        .b_sel      (flagb_sel_e'(flag_cfg[5:4])),
        .sign       (sign_o),
        .dir        (dir_up),
        .flag_a_n   (flag_a_n),
        .flag_b     (flag_b)
    );

    assign evt_carry  = evt.carry;
    assign evt_borrow = evt.borrow;
    assign evt_cmp    = evt.cmp;
    assign evt_idx    = evt.idx;

endmodule

// File: rtl/pos_counter_chk.sv
// Property checker for pos_counter, attached by bind.
// Assumes it observes top-level ports only.
module pos_counter_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_up,
    input logic [3:0]       mode_cfg,
    input logic [7:0]       flag_cfg,
    input logic [WIDTH-1:0] limit_val,
    input logic             clr_cnt,
    input logic             ld_cnt,
    input logic             clr_stat,
    input logic [WIDTH-1:0] cnt_val,
    input logic             evt_carry,
    input logic             evt_borrow,
    input logic             sign_o,
    input logic             cnt_en,
    input logic             flag_a_n
);

    // R2
    carry_borrow_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_carry && evt_borrow));

    // R12
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt |=> (cnt_val == '0));

    // R10
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_cfg[6] && !clr_cnt && !ld_cnt && (mode_cfg[3:2] == 2'b00))
        |=> (cnt_val == $past(cnt_val)));

    // R4
    range_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_cfg[1:0] == 2'b10) && cnt_up && (cnt_val == limit_val) &&
         !clr_cnt && !ld_cnt && (mode_cfg[3:2] == 2'b00))
        |=> (cnt_val == $past(cnt_val)));

    // R3
    once_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mode_cfg[1:0]) == 2'b01) && (evt_carry || evt_borrow)) |-> !cnt_en);

    // R7
    latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_cfg[7] && !flag_a_n && !clr_stat)
        |=> (!flag_a_n || !$stable(flag_cfg)));

    // R13
    borrow_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_borrow |-> sign_o);

endmodule

bind pos_counter pos_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_up     (cnt_up),
    .mode_cfg   (mode_cfg),
    .flag_cfg   (flag_cfg),
    .limit_val  (limit_val),
    .clr_cnt    (clr_cnt),
    .ld_cnt     (ld_cnt),
    .clr_stat   (clr_stat),
    .cnt_val    (cnt_val),
    .evt_carry  (evt_carry),
    .evt_borrow (evt_borrow),
    .sign_o     (sign_o),
    .cnt_en     (cnt_en),
    .flag_a_n   (flag_a_n)
);

// File: tb/pos_counter_tb.sv
`timescale 1ns/1ps
module pos_counter_tb;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_pulse = 1'b0;
    logic         cnt_up = 1'b0;
    logic         idx_n = 1'b1;
    logic [3:0]   mode_cfg = '0;
    logic [7:0]   flag_cfg = '0;
    logic [W-1:0] limit_val = '0;
    logic         clr_cnt = 1'b0;
    logic         ld_cnt = 1'b0;
    logic         snap_req = 1'b0;
    logic         clr_stat = 1'b0;
    logic [W-1:0] cnt_val;
    logic [W-1:0] snap_val;
    logic         evt_carry, evt_borrow, evt_cmp, evt_idx;
    logic         sign_o, dir_up, cnt_en, flag_a_n, flag_b;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    pos_counter #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_pulse(cnt_pulse), .cnt_up(cnt_up),
        .idx_n(idx_n), .mode_cfg(mode_cfg), .flag_cfg(flag_cfg),
        .limit_val(limit_val), .clr_cnt(clr_cnt), .ld_cnt(ld_cnt),
        .snap_req(snap_req), .clr_stat(clr_stat), .cnt_val(cnt_val),
        .snap_val(snap_val), .evt_carry(evt_carry), .evt_borrow(evt_borrow),
        .evt_cmp(evt_cmp), .evt_idx(evt_idx), .sign_o(sign_o), .dir_up(dir_up),
        .cnt_en(cnt_en), .flag_a_n(flag_a_n), .flag_b(flag_b)
    );

    // Behavioural reference state
    logic [W-1:0] m_cnt, m_snap;
    logic [3:0]   m_evt, m_sticky;   // [0] carry [1] borrow [2] cmp [3] index
    logic         m_halt, m_sign, m_dir, m_idx_prev;

    always @(posedge clk) begin
        logic ie, dclr, dld, dsnap, go, cy, bw, cp;
        logic [W-1:0] nv;
        if (!rst_n) begin
            m_cnt = '0; m_snap = '0; m_evt = '0; m_sticky = '0;
            m_halt = 0; m_sign = 0; m_dir = 1; m_idx_prev = 1;
        end else begin
            ie = m_idx_prev && !idx_n;
            m_idx_prev = idx_n;
            dclr  = clr_cnt  || (ie && mode_cfg[3:2] == 2'd2);
            dld   = ld_cnt   || (ie && mode_cfg[3:2] == 2'd1);
            dsnap = snap_req || (ie && mode_cfg[3:2] == 2'd3);
            if (clr_stat) m_sticky = '0; else m_sticky = m_sticky | m_evt;
            if (dsnap) m_snap = m_cnt;
            go = cnt_pulse && !flag_cfg[6] && !m_halt && !dclr && !dld;
            cy = 0; bw = 0; cp = 0; nv = m_cnt;
            if (go) begin
                case (mode_cfg[1:0])
                    2'd0, 2'd1: if (cnt_up) begin cy = (m_cnt == '1); nv = m_cnt + 1; end
                                else begin bw = (m_cnt == 0); nv = m_cnt - 1; end
                    2'd2: if (cnt_up) begin if (m_cnt != limit_val) nv = m_cnt + 1; end
                          else if (m_cnt != 0) nv = m_cnt - 1;
                    default: if (cnt_up) begin
                                 if (m_cnt == limit_val) begin nv = 0; cy = 1; end else nv = m_cnt + 1;
                             end else begin
                                 if (m_cnt == 0) begin nv = limit_val; bw = 1; end else nv = m_cnt - 1;
                             end
                endcase
                cp = (nv != m_cnt) && (nv == limit_val) && (cnt_up || mode_cfg[1:0] < 2);
                m_dir = cnt_up;
                if (mode_cfg[1:0] == 2'd1 && (cy || bw)) m_halt = 1;
                if (bw) m_sign = 1; else if (cy) m_sign = 0;
            end
            if (dclr) begin m_cnt = '0; m_halt = 0; end
            else if (dld) begin m_cnt = limit_val; m_halt = 0; end
            else m_cnt = nv;
            m_evt = {ie, cp, bw, cy};
        end
    end

    task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic fa, fb;
        fa = flag_cfg[7] ? !(|(m_evt & flag_cfg[3:0])) : !(|((m_sticky | m_evt) & flag_cfg[3:0]));
        case (flag_cfg[5:4])
            2'd1:    fb = m_sign;
            2'd2:    fb = m_dir;
            default: fb = 1'b1;
        endcase
        chk(cur_req, "cnt_val", cnt_val, m_cnt);
        chk(cur_req, "snap_val", snap_val, m_snap);
        chk(cur_req, "evt_carry", W'(evt_carry), W'(m_evt[0]));
        chk(cur_req, "evt_borrow", W'(evt_borrow), W'(m_evt[1]));
        chk(cur_req, "evt_cmp", W'(evt_cmp), W'(m_evt[2]));
        chk(cur_req, "evt_idx", W'(evt_idx), W'(m_evt[3]));
        chk(cur_req, "sign_o", W'(sign_o), W'(m_sign));
        chk(cur_req, "dir_up", W'(dir_up), W'(m_dir));
        chk(cur_req, "cnt_en", W'(cnt_en), W'(!flag_cfg[6] && !m_halt));
        chk(cur_req, "flag_a_n", W'(flag_a_n), W'(fa));
        chk(cur_req, "flag_b", W'(flag_b), W'(fb));
    endtask

    task automatic cyc();
        @(negedge clk);
        compare_all();
        clr_cnt = 0; ld_cnt = 0; snap_req = 0; clr_stat = 0;
    endtask

    task automatic pulses(int n, bit up);
        cnt_pulse = 1; cnt_up = up;
        repeat (n) cyc();
        cnt_pulse = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (2) cyc();
        chk("R1", "cnt reset", cnt_val, 0);
        chk("R1", "flag_a_n reset", W'(flag_a_n), 1);
        chk("R1", "flag_b reset", W'(flag_b), 1);
        chk("R1", "cnt_en reset", W'(cnt_en), 1);
        chk("R1", "dir reset", W'(dir_up), 1);
        rst_n = 1;

        cur_req = "R2";
        limit_val = 32'hFFFF_FFFE; ld_cnt = 1; cyc();
        pulses(2, 1);
        chk("R2", "up wrap cnt", cnt_val, 0);
        chk("R2", "carry", W'(evt_carry), 1);
        pulses(1, 1);
        pulses(2, 0);
        chk("R2", "down wrap cnt", cnt_val, 32'hFFFF_FFFF);
        chk("R2", "borrow", W'(evt_borrow), 1);
        chk("R13", "sign after borrow", W'(sign_o), 1);
        pulses(1, 0);
        chk("R6", "free down compare", W'(evt_cmp), 1);
        pulses(2, 1);
        chk("R13", "sign after carry", W'(sign_o), 0);

        cur_req = "R7";
        clr_stat = 1; cyc();
        flag_cfg = 8'h01;
        idx_n = 0; cyc(); idx_n = 1;
        chk("R7", "unenabled index keeps flag", W'(flag_a_n), 1);
        chk("R11", "index event", W'(evt_idx), 1);
        limit_val = 32'hFFFF_FFFF; ld_cnt = 1; cyc();
        pulses(1, 1);
        chk("R7", "latched low on carry", W'(flag_a_n), 0);
        repeat (3) cyc();
        chk("R7", "latched stays low", W'(flag_a_n), 0);
        clr_stat = 1; cyc();
        chk("R7", "cleared by status clear", W'(flag_a_n), 1);

        cur_req = "R8";
        flag_cfg = 8'h84; limit_val = 5; clr_cnt = 1; cyc();
        pulses(4, 1);
        chk("R8", "no compare yet", W'(flag_a_n), 1);
        pulses(1, 1);
        chk("R8", "pulse low", W'(flag_a_n), 0);
        cyc();
        chk("R8", "pulse ends", W'(flag_a_n), 1);

        cur_req = "R4";
        flag_cfg = 8'h00; mode_cfg = 4'b0010; limit_val = 3; clr_cnt = 1; cyc();
        pulses(5, 1);
        chk("R4", "freeze at limit", cnt_val, 3);
        chk("R6", "no compare when frozen", W'(evt_cmp), 0);
        pulses(5, 0);
        chk("R4", "freeze at zero", cnt_val, 0);
        pulses(1, 1);
        chk("R4", "resume", cnt_val, 1);
        limit_val = 6; ld_cnt = 1; cyc();
        limit_val = 4;
        pulses(2, 0);
        chk("R6", "range down onto limit cnt", cnt_val, 4);
        chk("R6", "range down onto limit no cmp", W'(evt_cmp), 0);

        cur_req = "R5";
        mode_cfg = 4'b0011; flag_cfg = 8'h83; limit_val = 2; clr_cnt = 1; cyc();
        pulses(2, 1);
        chk("R6", "modn up compare", W'(evt_cmp), 1);
        pulses(1, 1);
        chk("R5", "up wrap to zero", cnt_val, 0);
        chk("R5", "wrap marker on flag", W'(flag_a_n), 0);
        pulses(1, 1);
        pulses(2, 0);
        chk("R5", "down wrap to limit", cnt_val, 2);
        chk("R5", "borrow marker", W'(evt_borrow), 1);
        chk("R6", "modn down no compare", W'(evt_cmp), 0);

        cur_req = "R3";
        mode_cfg = 4'b0001; flag_cfg = 8'h00; limit_val = 32'hFFFF_FFFE; ld_cnt = 1; cyc();
        pulses(2, 1);
        chk("R3", "halt after carry", W'(cnt_en), 0);
        pulses(3, 1);
        chk("R3", "pulses ignored", cnt_val, 0);
        ld_cnt = 1; cyc();
        chk("R3", "load restarts", W'(cnt_en), 1);
        clr_cnt = 1; cyc();
        pulses(1, 0);
        chk("R3", "halt after borrow", W'(cnt_en), 0);
        clr_cnt = 1; cyc();
        chk("R3", "clear restarts", W'(cnt_en), 1);

        cur_req = "R10";
        mode_cfg = 4'b0000; flag_cfg = 8'h40;
        pulses(3, 1);
        chk("R10", "disabled count", cnt_val, 0);
        chk("R10", "enable low", W'(cnt_en), 0);

        cur_req = "R9";
        flag_cfg = 8'h20;
        pulses(1, 1);
        chk("R9", "dir up", W'(flag_b), 1);
        pulses(1, 0);
        chk("R9", "dir down", W'(flag_b), 0);
        flag_cfg = 8'h10;
        pulses(1, 0);
        chk("R9", "sign negative", W'(flag_b), 1);
        pulses(1, 1);
        chk("R9", "sign positive", W'(flag_b), 0);
        flag_cfg = 8'h00; cyc();
        chk("R9", "fixed high", W'(flag_b), 1);

        cur_req = "R11";
        mode_cfg = 4'b0100; limit_val = 32'h77;
        idx_n = 0; cyc();
        chk("R11", "index load", cnt_val, 32'h77);
        chk("R11", "index event", W'(evt_idx), 1);
        cyc();
        chk("R11", "held low no event", W'(evt_idx), 0);
        idx_n = 1; cyc();
        mode_cfg = 4'b1000; idx_n = 0; cyc();
        chk("R11", "index clear", cnt_val, 0);
        idx_n = 1;
        pulses(3, 1);
        mode_cfg = 4'b1100; idx_n = 0; cyc();
        chk("R11", "index snapshot", snap_val, 3);
        idx_n = 1; cyc();
        mode_cfg = 4'b0000; idx_n = 0; cyc();
        chk("R11", "index off keeps count", cnt_val, 3);
        idx_n = 1; cyc();

        cur_req = "R12";
        limit_val = 9; clr_cnt = 1; ld_cnt = 1; cnt_pulse = 1; cnt_up = 1; cyc();
        cnt_pulse = 0;
        chk("R12", "clear beats load and count", cnt_val, 0);
        ld_cnt = 1; cnt_pulse = 1; cyc(); cnt_pulse = 0;
        chk("R12", "load beats count", cnt_val, 9);
        snap_req = 1; cnt_pulse = 1; cyc(); cnt_pulse = 0;
        chk("R12", "snapshot pre-edge", snap_val, 9);
        chk("R12", "count after snapshot", cnt_val, 10);

        cur_req = "R1..R13 random";
        for (int i = 0; i < 3000; i++) begin
            if (i % 200 == 0) begin
                mode_cfg = 4'($urandom);
                flag_cfg = 8'($urandom);
                if ($urandom_range(3) != 0) flag_cfg[6] = 1'b0;
                case ($urandom_range(2))
                    0: limit_val = W'($urandom_range(7));
                    1: limit_val = 32'hFFFF_FFF0 | W'($urandom_range(15));
                    default: limit_val = W'($urandom);
                endcase
            end
            cnt_pulse = ($urandom_range(9) < 7);
            cnt_up    = 1'($urandom);
            if ($urandom_range(7) == 0) idx_n = !idx_n;
            clr_cnt  = ($urandom_range(39) == 0);
            ld_cnt   = ($urandom_range(29) == 0);
            snap_req = ($urandom_range(29) == 0);
            clr_stat = ($urandom_range(19) == 0);
            cyc();
        end
        cnt_pulse = 0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule